// File: doc/BRIEF.md
# Receive FIFO Interrupt Timeout Controller

This block decides when the receive side of a serial port asks for service. It watches a strobe that pulses once for each byte written into the receive FIFO, together with the FIFO fill count after that write. It raises a receive-data-full flag as soon as the fill count reaches a programmable trigger level. A short burst can stop below that level. For that case the block keeps an idle timer, and when no further byte arrives for 15 elementary time units the timer raises the same flag. This keeps an interactive console responsive even when the trigger level is set high.

One elementary time unit is one bit time at a fixed 9600 bit/s. It is derived from the system clock by a prescaler of `CLK_HZ / 9600` cycles, and any programmed line rate has no effect on it. The flag is sticky. Software clears it with a strobe. The interrupt line is the flag qualified by an enable bit. The FIFO storage, serialization and baud generation are outside this block.

Top module: `uart_rx_timeout_irq`

## Requirements
- R1: A byte strobe while the fill count is at or above the effective trigger level sets the flag on the next rising clock edge.
- R2: A byte strobe while the fill count is below the effective trigger level restarts the idle timeout. If no further byte arrives, the flag sets exactly `15 * DIV` clock cycles after the edge that captured that strobe.
- R3: `DIV` equals `CLK_HZ / 9600`. The prescaler restarts from zero on every byte strobe, so a restart in the middle of a time unit adds no partial unit.
- R4: A byte strobe at or above the effective trigger level cancels any pending idle timeout, and the cancelled timeout never sets the flag.
- R5: `rx_irq_o` is high exactly while the flag is high and `rx_int_en_i` is 1. This holds whether the flag was set by the trigger level or by the timeout, and the line follows a later change of the enable.
- R6: A trigger value of 0 acts as 1, and values above the FIFO depth (16) act as 16.
- R7: The flag holds until a clear strobe. A clear is ignored while the fill count is at or above the effective trigger level.
- R8: A timeout that has fired does not fire again until another byte below the trigger level is received.
- R9: When a set and a clear happen in the same cycle, the set wins.
- R10: While `rst_ni` is low, the flag, the interrupt and the idle timer are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Pulses for one cycle per byte written into the FIFO |
| fifo_cnt_i | input | CNT_W | FIFO fill count, including the byte being written |
| trig_lvl_i | input | CNT_W | Receive trigger level |
| rx_int_en_i | input | 1 | Receive interrupt enable |
| flag_clr_i | input | 1 | Clear strobe for the data-full flag |
| rdf_o | output | 1 | Receive-data-full flag |
| rx_irq_o | output | 1 | Receive interrupt line |

## Verification
The flag is registered. A trigger-level hit therefore shows one edge after the strobe, a timeout shows exactly `15 * DIV` edges after the last byte below the trigger level, and a clear shows one edge after the clear. The interrupt follows the flag and the enable with no added delay. The bench drives inputs on the falling edge. A behavioural model counts down the remaining idle cycles and updates on each rising edge, and both outputs are compared with it 1 ns after every rising edge, once the registers have settled. An early or late timeout therefore fails in the exact cycle where it goes wrong.

// File: rtl/uart_rxto_pkg.sv
package uart_rxto_pkg;

  localparam int unsigned ETU_BAUD_HZ = 9600;
  localparam int unsigned IDLE_ETU_DEF = 15;

  // Trigger level clamped to 1..depth
  function automatic int unsigned eff_trig(int unsigned raw, int unsigned depth);
    if (raw == 0) return 1;
    if (raw > depth) return depth;
    return raw;
  endfunction

endpackage

// File: rtl/rxto_etu_prescaler.sv
module rxto_etu_prescaler #(
  parameter int unsigned DIV_CYC = 13020
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);

  generate
    if (DIV_CYC <= 1) begin : g_bypass
      assign tick_o = run_i && !restart_i;
    end else begin : g_count
      localparam int unsigned DW = $clog2(DIV_CYC);
      localparam logic [DW-1:0] LAST = DW'(DIV_CYC - 1);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (run_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign tick_o = run_i && !restart_i && (cnt_q == LAST);

      assert_presc_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
      assert_presc_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
  parameter int unsigned DIV_CYC  = 13020,
  parameter int unsigned IDLE_ETU = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic cancel_i,
  output logic expire_o,
  output logic armed_o
);

  localparam int unsigned EW = (IDLE_ETU > 1) ? $clog2(IDLE_ETU) : 1;
  localparam logic [EW-1:0] ETU_LAST = EW'(IDLE_ETU - 1);

  logic          armed_q;
  logic [EW-1:0] etu_q;
  logic          tick;

  rxto_etu_prescaler #(.DIV_CYC(DIV_CYC)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(arm_i || cancel_i),
    .run_i    (armed_q),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      etu_q   <= '0;
    end else if (cancel_i) begin
      armed_q <= 1'b0;
      etu_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      etu_q   <= '0;
    end else if (tick) begin
      if (etu_q == ETU_LAST) begin
        armed_q <= 1'b0;
        etu_q   <= '0;
      end else begin
        etu_q <= etu_q + 1'b1;
      end
    end
  end

  assign expire_o = tick && (etu_q == ETU_LAST);
  assign armed_o  = armed_q;

  assert_fire_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !armed_o && !expire_o);
  assert_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !armed_o && !expire_o);
  assert_etu_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    etu_q <= ETU_LAST);

endmodule

// File: rtl/rxto_trig_cmp.sv
module rxto_trig_cmp
  import uart_rxto_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [CNT_W-1:0] trig_lvl_i,
  output logic             at_trig_o
);

  logic [CNT_W-1:0] eff;

  always_comb begin
    eff       = CNT_W'(eff_trig(int'(trig_lvl_i), DEPTH));
    at_trig_o = fifo_cnt_i >= eff;
  end

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_block_i,
  output logic rdf_o
);

  logic rdf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdf_q <= 1'b0;
    else if (set_i)                   rdf_q <= 1'b1;
    else if (clr_i && !clr_block_i)   rdf_q <= 1'b0;
  end

  assign rdf_o = rdf_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> rdf_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(rdf_o));
  assert_clr_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && clr_i && clr_block_i |=> $stable(rdf_o));

endmodule

// File: rtl/uart_rx_timeout_irq.sv
module uart_rx_timeout_irq
  import uart_rxto_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 125_000_000,
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned IDLE_ETU = IDLE_ETU_DEF,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [CNT_W-1:0] trig_lvl_i,
  input  logic             rx_int_en_i,
  input  logic             flag_clr_i,
  output logic             rdf_o,
  output logic             rx_irq_o
);

  localparam int unsigned DIV_RAW = CLK_HZ / ETU_BAUD_HZ;
  localparam int unsigned DIV_CYC = (DIV_RAW > 0) ? DIV_RAW : 1;

  logic at_trig;
  logic hit_trig;
  logic below_byte;
  logic expire;
  logic armed;
  logic rdf;

  rxto_trig_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cmp (
    .fifo_cnt_i(fifo_cnt_i),
    .trig_lvl_i(trig_lvl_i),
    .at_trig_o (at_trig)
  );

  assign hit_trig   = byte_valid_i && at_trig;
  assign below_byte = byte_valid_i && !at_trig;

  rxto_idle_timer #(.DIV_CYC(DIV_CYC), .IDLE_ETU(IDLE_ETU)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (below_byte),
    .cancel_i(hit_trig),
    .expire_o(expire),
    .armed_o (armed)
  );

  rxto_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (hit_trig || expire),
    .clr_i      (flag_clr_i),
    .clr_block_i(at_trig),
    .rdf_o      (rdf)
  );

  assign rdf_o    = rdf;
  assign rx_irq_o = rdf && rx_int_en_i;

  assert_trig_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && at_trig |=> rdf_o);
  assert_trig_cancels_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && at_trig |=> !armed);
  assert_below_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i && !at_trig |=> armed);

endmodule

// File: tb/uart_rx_timeout_irq_test.sv
module uart_rx_timeout_irq_test;

  localparam int DEPTH  = 16;
  localparam int CW     = 5;
  localparam int CLK_HZ = 76800;  // 8 clocks per time unit
  localparam int DIV    = CLK_HZ / 9600;
  localparam int TO     = 15 * DIV;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          byte_v = 1'b0;
  logic [CW-1:0] fifo_cnt = '0;
  logic [CW-1:0] trig = '0;
  logic          rie = 1'b0;
  logic          clr = 1'b0;
  logic          rdf_o, rx_irq_o;

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_timeout_irq #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_v), .fifo_cnt_i(fifo_cnt),
    .trig_lvl_i(trig), .rx_int_en_i(rie), .flag_clr_i(clr),
    .rdf_o(rdf_o), .rx_irq_o(rx_irq_o)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R10";
  bit    done = 0;

  bit m_flag = 0;
  int m_rem = 0;
  bit m_at, m_set, m_fire;

  function automatic int eff(int t);
    if (t == 0) return 1;
    if (t > DEPTH) return DEPTH;
    return t;
  endfunction

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model, updated per rising edge, compared 1 ns later
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_flag = 0;
      m_rem  = 0;
    end else begin
      m_at   = int'(fifo_cnt) >= eff(int'(trig));
      m_set  = 0;
      m_fire = 0;
      if (byte_v && m_at) begin
        m_set = 1;
        m_rem = 0;
      end else if (byte_v) begin
        m_rem = TO;
      end else if (m_rem > 0) begin
        m_rem--;
        if (m_rem == 0) m_fire = 1;
      end
      if (m_set || m_fire) m_flag = 1;
      else if (clr && !m_at) m_flag = 0;
    end
    #1;
    if (!done) begin
      chk(cur_req, rdf_o, m_flag, "rdf_o");
      chk(cur_req, rx_irq_o, m_flag && rie, "rx_irq_o");
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int c);
    @(negedge clk);
    byte_v   = 1'b1;
    fifo_cnt = CW'(c);
    @(negedge clk);
    byte_v = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    cur_req = "R10";
    idle(3);
    chk("R10", rdf_o, 1'b0, "reset rdf_o");
    chk("R10", rx_irq_o, 1'b0, "reset rx_irq_o");
    rst_ni = 1'b1;
    trig = CW'(4);
    rie  = 1'b1;
    idle(2);

    // R2/R3: below-trigger bytes restart timeout mid-unit
    cur_req = "R2";
    send(1); idle(9);
    send(2); idle(9);
    send(3); idle(TO + 10);
    cur_req = "R7"; pulse_clr(); idle(3);

    // R1/R4: reaching trigger sets immediately and cancels timeout
    cur_req = "R1";
    send(1); idle(20);
    send(4); idle(3);
    cur_req = "R7"; pulse_clr(); idle(3);   // blocked: count at trigger
    @(negedge clk); fifo_cnt = '0;
    pulse_clr(); idle(2);
    cur_req = "R4"; idle(TO + 20);

    // R8: single firing
    cur_req = "R8";
    send(1); idle(TO + 5);
    fifo_cnt = '0;
    pulse_clr(); idle(TO + 20);

    // R5: enable gating
    cur_req = "R5";
    rie = 1'b0;
    send(2); idle(TO + 5);
    chk("R5", rx_irq_o, 1'b0, "irq masked");
    rie = 1'b1; idle(3);
    chk("R5", rx_irq_o, 1'b1, "irq unmasked");
    fifo_cnt = '0; pulse_clr(); idle(2);

    // R6: trigger clamping
    cur_req = "R6";
    trig = '0;
    send(1); idle(3);
    fifo_cnt = '0; pulse_clr(); idle(2);
    trig = CW'(20);
    send(15); idle(5);
    chk("R6", rdf_o, 1'b0, "15 below clamped 16");
    send(16); idle(3);
    chk("R6", rdf_o, 1'b1, "16 at clamped 16");
    fifo_cnt = '0; pulse_clr(); idle(2);

    // R9: set beats clear
    cur_req = "R9";
    trig = CW'(4);
    @(negedge clk);
    byte_v = 1'b1; fifo_cnt = CW'(4); clr = 1'b1;
    @(negedge clk);
    byte_v = 1'b0; clr = 1'b0;
    idle(2);
    chk("R9", rdf_o, 1'b1, "set over clear");
    fifo_cnt = '0; pulse_clr(); idle(5);

    // R3: restart late in a time unit
    cur_req = "R3";
    send(1); idle(DIV * 3 + 6);
    send(2); idle(TO + 10);
    fifo_cnt = '0; pulse_clr(); idle(3);

    done = 1;
    idle(2);
    finish_run();
  end

endmodule